// File: doc/BRIEF.md
# Lockdown-Aware Victim Way Selector

This block chooses which way of a set-associative cache is replaced when a line fill needs room. For each allocate request it looks at the valid bits of the addressed set and at a per-way lock mask, chosen from a data mask or an instruction mask according to the class of the requester. Locked ways are excluded from replacement. An invalid, unlocked way is filled first. Only when no such way exists is a valid way evicted, chosen by a rotating search that starts at a pseudo-random pointer.

The result appears on registered outputs one clock after the request is sampled. If every way is locked, a no-victim flag is raised in place of a victim and no allocation takes place. Tag lookup, the data path and the storage of the lock masks are outside this block.

Top module: `victim_sel`

## Requirements
- R1: A way whose bit in the applied lock mask is 1 is never reported as the victim.
- R2: If any way is both invalid (`set_valid` bit 0) and unlocked, the victim is the lowest-indexed such way.
- R3: If every way is valid or locked and at least one is unlocked, the victim is the first unlocked way met when searching upward from the pointer, the pointer position included, wrapping from way WAYS-1 to way 0.
- R4: The applied lock mask is `instr_lock` when `alloc_is_instr` is 1 and `data_lock` when it is 0.
- R5: If every way is locked, `no_victim` is 1, `victim_vld` is 0, and the pointer does not advance.
- R6: The pointer is a 4-bit LFSR reset to 4'b0001 whose next value is {s[2:0], s[3]^s[2]}; it advances once per allocation that takes place, and its value modulo WAYS is the search start.
- R7: `victim_vld`, `victim_way` and `no_victim` reflect the request sampled at the previous rising edge; after a cycle with no request, `victim_vld` and `no_victim` are both 0.
- R8: After reset `victim_vld`, `no_victim` and `victim_way` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_req | input | 1 | Allocate request, sampled at rising edge |
| alloc_is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| set_valid | input | WAYS | Valid bit per way of the addressed set |
| data_lock | input | WAYS | Lock mask for data accesses |
| instr_lock | input | WAYS | Lock mask for instruction fetches |
| victim_vld | output | 1 | A victim way was chosen |
| victim_way | output | log2(WAYS) | Index of the chosen way |
| no_victim | output | 1 | All ways were locked, no allocation |

## Verification
The bench targets the all-locked set, where a wrong design would name a locked way or let the pointer drift so every later choice shifts. It uses a single unlocked way above and below the pointer to catch a search that misses the wrap or skips the pointer's own position. Sets with several free ways catch a design that picks the highest instead of the lowest, and opposing data and instruction masks catch a swapped mask select.

// File: rtl/victim_sel.sv
module victim_sel #(
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_req,
  input  logic                    alloc_is_instr,
  input  logic [WAYS-1:0]         set_valid,
  input  logic [WAYS-1:0]         data_lock,
  input  logic [WAYS-1:0]         instr_lock,
  output logic                    victim_vld,
  output logic [$clog2(WAYS)-1:0] victim_way,
  output logic                    no_victim
);
  localparam int WW = $clog2(WAYS);

  logic [3:0]      lfsr;
  logic [WAYS-1:0] mask, free;
  logic [WW-1:0]   ptr, fill_way, rot_way, idx;
  logic            fill_hit, rot_hit;

  assign mask = alloc_is_instr ? instr_lock : data_lock;
  assign free = ~set_valid & ~mask;
  assign ptr  = lfsr[WW-1:0];

  always_comb begin
    fill_hit = 1'b0;
    fill_way = '0;
    rot_hit  = 1'b0;
    rot_way  = '0;
    idx      = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (free[i]) begin
        fill_hit = 1'b1;
        fill_way = WW'(i);
      end
      idx = ptr + WW'(i);
      if (!mask[idx]) begin
        rot_hit = 1'b1;
        rot_way = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr       <= 4'b0001;
      victim_vld <= 1'b0;
      victim_way <= '0;
      no_victim  <= 1'b0;
    end else begin
      victim_vld <= alloc_req && rot_hit;
      no_victim  <= alloc_req && !rot_hit;
      if (alloc_req && rot_hit) begin
        victim_way <= fill_hit ? fill_way : rot_way;
        lfsr       <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      end
    end
  end
endmodule

module victim_sel_chk #(
  parameter int WAYS = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    alloc_req,
  input logic                    alloc_is_instr,
  input logic [WAYS-1:0]         set_valid,
  input logic [WAYS-1:0]         data_lock,
  input logic [WAYS-1:0]         instr_lock,
  input logic                    victim_vld,
  input logic [$clog2(WAYS)-1:0] victim_way,
  input logic                    no_victim
);
  logic [WAYS-1:0] m_q, v_q;
  logic            req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; v_q <= '0; req_q <= 1'b0;
    end else begin
      m_q   <= alloc_is_instr ? instr_lock : data_lock;
      v_q   <= set_valid;
      req_q <= alloc_req;
    end
  end

  p_unlocked_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> !m_q[victim_way]);
  p_invalid_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && (|(~v_q & ~m_q))) |-> !v_q[victim_way]);
  p_all_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim |-> (&m_q));
  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(victim_vld && no_victim));
  p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (victim_vld || no_victim));
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> (!victim_vld && !no_victim));
endmodule

bind victim_sel victim_sel_chk #(.WAYS(WAYS)) u_chk (.*);

// File: tb/sim_victim_sel.sv
`timescale 1ns/1ps
module sim_victim_sel;
  localparam int WAYS = 8;
  localparam int WW = $clog2(WAYS);

  logic clk = 0, rst_n = 0, alloc_req = 0, alloc_is_instr = 0;
  logic [WAYS-1:0] set_valid = '0, data_lock = '0, instr_lock = '0;
  logic victim_vld, no_victim;
  logic [WW-1:0] victim_way;

  int checks = 0, fails = 0;
  logic [3:0] lfsr_m = 4'b0001;
  bit done = 0;

  always #2.5 clk = ~clk;

  victim_sel #(.WAYS(WAYS)) u0 (.*);

  function automatic int pick(logic [WAYS-1:0] v, logic [WAYS-1:0] m, int p);
    for (int i = 0; i < WAYS; i++) if (!v[i] && !m[i]) return i;
    for (int i = 0; i < WAYS; i++) if (!m[(p + i) % WAYS]) return (p + i) % WAYS;
    return -1;
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic alloc(logic [WAYS-1:0] v, logic [WAYS-1:0] dl, logic [WAYS-1:0] il,
                       logic ins, string r);
    int e;
    @(negedge clk);
    set_valid = v; data_lock = dl; instr_lock = il; alloc_is_instr = ins; alloc_req = 1;
    e = pick(v, ins ? il : dl, int'(lfsr_m) % WAYS);
    @(negedge clk);
    alloc_req = 0;
    if (e < 0) begin
      chk({r, " no_victim"}, no_victim, 1);
      chk({r, " vld"}, victim_vld, 0);
    end else begin
      chk({r, " vld"}, victim_vld, 1);
      chk({r, " way"}, victim_way, e);
      lfsr_m = {lfsr_m[2:0], lfsr_m[3] ^ lfsr_m[2]};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R8 vld", victim_vld, 0);
    chk("R8 nov", no_victim, 0);
    chk("R8 way", victim_way, 0);
    rst_n = 1;
    // R2 lowest free way
    alloc(8'b1001_0011, 8'h00, 8'hFF, 0, "R2");
    alloc(8'b0000_0000, 8'b0000_0111, 8'h00, 0, "R2 R1");
    // R4 mask selection
    alloc(8'hFF, 8'b1111_1110, 8'b0111_1111, 1, "R4 instr");
    alloc(8'hFF, 8'b1111_1110, 8'b0111_1111, 0, "R4 data");
    // R5 all locked, pointer held (R6)
    alloc(8'h00, 8'hFF, 8'h00, 0, "R5");
    alloc(8'hFF, 8'h00, 8'hFF, 1, "R5 instr");
    // R3 / R6 rotating search, single unlocked way at each position
    for (int k = 0; k < WAYS; k++)
      alloc(8'hFF, ~(8'b1 << k), 8'h00, 0, "R3 single");
    for (int k = 0; k < 20; k++)
      alloc(8'hFF, 8'h00, 8'h00, 0, "R6 sequence");
    // R7 idle cycle
    @(negedge clk);
    chk("R7 idle vld", victim_vld, 0);
    chk("R7 idle nov", no_victim, 0);
    // random R1 R2 R3 R4
    for (int k = 0; k < 400; k++) begin
      logic [WAYS-1:0] v, dl, il;
      v = WAYS'($urandom); dl = WAYS'($urandom & $urandom); il = WAYS'($urandom | $urandom);
      if ($urandom_range(0, 9) == 0) dl = '1;
      alloc(v, dl, il, 1'($urandom), "R1 R3 random");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule